// File: doc/BRIEF.md
# Queued SPI Master

This block is an SPI master that works through a short list of transfers without outside help. Before a run, the host fills two small internal arrays through a write port. The command array holds one word per entry, giving the transfer length and the chip-select pattern. The transmit array holds the outgoing word for each entry. The host then picks a first and a last entry and pulses `go`. The block runs every entry from the first to the last, in order, and wraps from entry 15 back to entry 0. For each entry it drives the chip-select field and toggles SCK. It shifts the word out on MOSI and the answer in from MISO, most significant bit first. The received word goes into a receive array at the same index as its command entry.

The serial clock comes from a modulus counter on the system clock. Its half period is `baud` system clocks, so the SCK frequency is the system clock divided by twice `baud`. Clock polarity and phase are inputs, and all four combinations are supported. The block only ever acts as master. If `ss_n` is driven low while `mstr_en` is high, the block flags a mode fault. It also drops the transfer at once and returns its pins to idle.

Top module: `qspi_master`

## Requirements
- R1: After reset, `busy`, `done` and `modf` are 0, `pcs` is all ones (no device selected) and `sck` equals `cpol`.
- R2: SCK rests at `cpol` while no transfer is running. With `cpha`=0, MOSI is valid before the first SCK edge, MISO is sampled on odd-numbered edges (1st, 3rd, ...) and MOSI changes on even-numbered edges. With `cpha`=1, MOSI changes on odd-numbered edges and MISO is sampled on even-numbered edges. MOSI never changes on a sampling edge.
- R3: Each entry sends the low N bits of its transmit word, most significant of those bits first.
- R4: A command word holds the length code in bits [7:4] and the chip-select pattern in bits [3:0]. Length code 0 gives 16 bits, codes 1 to 7 give 8 bits, and codes 8 to 15 give that many bits. Each entry produces exactly 2N SCK edges.
- R5: Within an entry, consecutive SCK edges are exactly `baud` system clocks apart. A `baud` value below 2 is treated as 2.
- R6: Entries run from `qstart` to `qend` inclusive, in increasing index order, wrapping from 15 to 0. While an entry is being transferred, `pcs` carries that entry's bits [3:0]. `pcs` is all ones whenever `busy` is 0.
- R7: At the end of each entry, the N received bits are stored right-justified, with zeros above them, in the receive array at the entry's index. They are readable on `rd_data` at `rd_addr`.
- R8: When the last entry completes, `done` rises and `busy` falls together. An accepted `go` clears `done` and raises `busy` on the next clock.
- R9: `ss_n` low while `mstr_en` is high sets `modf` on the next clock. The same clock ends any transfer: `busy` goes to 0, `pcs` goes to all ones and SCK returns to `cpol`, without setting `done`. `modf` stays set until an accepted `go` clears it.
- R10: `go` is ignored when `mstr_en` is 0 or `ss_n` is 0. No transfer starts, no SCK edge appears and `done` keeps its value.
- R11: `wr_en` with `wr_tx`=1 writes `wr_data` to transmit entry `wr_addr`. With `wr_tx`=0 it writes `wr_data[7:0]` to command entry `wr_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mstr_en | input | 1 | Master mode enable |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | SCK phase select |
| baud | input | 8 | Half period of SCK in system clocks |
| qstart | input | 4 | First queue entry |
| qend | input | 4 | Last queue entry |
| go | input | 1 | Start pulse |
| wr_en | input | 1 | Array write strobe |
| wr_tx | input | 1 | 1 selects transmit array, 0 selects command array |
| wr_addr | input | 4 | Array write index |
| wr_data | input | 16 | Array write data |
| rd_addr | input | 4 | Receive array read index |
| rd_data | output | 16 | Receive array word at rd_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| pcs | output | 4 | Chip-select pattern, all ones when idle |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Slave-select input, low signals a mode fault |
| busy | output | 1 | Queue running |
| done | output | 1 | Queue finished |
| modf | output | 1 | Mode fault flag |

## Verification
The bench models an SPI slave that follows SCK. It collects MOSI on the sampling edges and shifts its own word out on MISO on the driving edges. The same four-entry queue runs once in each of the four polarity and phase combinations. Separate transmit and slave patterns make a wrong sampling edge, a reversed bit order or a missing right-justification show up as a different word. Those runs use lengths of 8, 12 and 16 bits, plus a reserved length code. These distinguish the length decode from a plain bit count. A ramp of `baud` values, including 0, checks the edge spacing. A queue from entry 14 to entry 1 shows the pointer wrap. Fault and ignored-start runs check that the pins return to idle or never leave it.

// File: rtl/qspi_master.sv
module qspi_master #(
  parameter int QD  = 16,
  parameter int CSW = 4,
  parameter int BRW = 8,
  parameter int AW  = $clog2(QD)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mstr_en,
  input  logic           cpol,
  input  logic           cpha,
  input  logic [BRW-1:0] baud,
  input  logic [AW-1:0]  qstart,
  input  logic [AW-1:0]  qend,
  input  logic           go,
  input  logic           wr_en,
  input  logic           wr_tx,
  input  logic [AW-1:0]  wr_addr,
  input  logic [15:0]    wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [15:0]    rd_data,
  output logic           sck,
  output logic           mosi,
  output logic [CSW-1:0] pcs,
  input  logic           miso,
  input  logic           ss_n,
  output logic           busy,
  output logic           done,
  output logic           modf
);
  localparam int DW = 16;
  localparam int CW = CSW + 4;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL} st_t;

  function automatic logic [4:0] len_of(input logic [3:0] code);
    if (code == 4'd0)      return 5'd16;
    else if (code < 4'd8)  return 5'd8;
    else                   return {1'b0, code};
  endfunction

  st_t            st;
  logic [CW-1:0]  cmd_mem [QD];
  logic [DW-1:0]  tx_mem  [QD];
  logic [DW-1:0]  rx_mem  [QD];
  logic [AW-1:0]  ptr, qend_q;
  logic [BRW-1:0] cnt;
  logic [4:0]     ecnt, nbits;
  logic [3:0]     dptr;
  logic [DW-1:0]  txw, rxs;
  logic           sck_q, mosi_q, cpol_q, cpha_q, done_q, modf_q;
  logic [CSW-1:0] pcs_q;

  wire            fault     = mstr_en & ~ss_n;
  wire [BRW-1:0]  baud_eff  = (baud < BRW'(2)) ? BRW'(2) : baud;
  wire            tick      = (cnt == '0);
  wire            start_ok  = (st == S_IDLE) & go & mstr_en & ss_n;
  wire [5:0]      span      = {nbits, 1'b0} - 6'd1;
  wire            last_edge = (ecnt == span[4:0]);
  wire            samp_edge = (ecnt[0] == cpha_q);
  wire            fin       = (st == S_TAIL) & tick;
  wire [AW-1:0]   ld_ptr    = (st == S_IDLE) ? qstart : ptr + AW'(1);
  wire [CW-1:0]   ld_cmd    = cmd_mem[ld_ptr];
  wire [4:0]      ld_len    = len_of(ld_cmd[CW-1 -: 4]);
  wire [DW-1:0]   ld_tx     = tx_mem[ld_ptr];
  wire            ld_pha    = (st == S_IDLE) ? cpha : cpha_q;
  wire            ld_pol    = (st == S_IDLE) ? cpol : cpol_q;
  wire            load      = start_ok | (fin & (ptr != qend_q));

  assign busy    = (st != S_IDLE);
  assign sck     = busy ? sck_q : cpol;
  assign mosi    = mosi_q;
  assign pcs     = pcs_q;
  assign done    = done_q;
  assign modf    = modf_q;
  assign rd_data = rx_mem[rd_addr];

  always_ff @(posedge clk)
    if (wr_en) begin
      if (wr_tx) tx_mem[wr_addr]  <= wr_data;
      else       cmd_mem[wr_addr] <= wr_data[CW-1:0];
    end

  always_ff @(posedge clk)
    if (fin && !fault) rx_mem[ptr] <= rxs;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr    <= '0;
      qend_q <= '0;
      cnt    <= '0;
      ecnt   <= '0;
      nbits  <= 5'd8;
      dptr   <= '0;
      txw    <= '0;
      rxs    <= '0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      pcs_q  <= '1;
    end else if (fault) begin
      st    <= S_IDLE;
      pcs_q <= '1;
    end else if (load) begin
      st     <= S_RUN;
      ptr    <= ld_ptr;
      if (st == S_IDLE) begin
        qend_q <= qend;
        cpol_q <= cpol;
        cpha_q <= cpha;
      end
      pcs_q  <= ld_cmd[CSW-1:0];
      nbits  <= ld_len;
      txw    <= ld_tx;
      rxs    <= '0;
      ecnt   <= '0;
      cnt    <= baud_eff - BRW'(1);
      sck_q  <= ld_pol;
      if (!ld_pha) begin
        mosi_q <= ld_tx[4'(ld_len - 5'd1)];
        dptr   <= 4'(ld_len - 5'd2);
      end else begin
        dptr   <= 4'(ld_len - 5'd1);
      end
    end else begin
      case (st)
        S_RUN:
          if (tick) begin
            cnt   <= baud_eff - BRW'(1);
            sck_q <= ~sck_q;
            if (samp_edge) rxs <= {rxs[DW-2:0], miso};
            else if (!last_edge) begin
              mosi_q <= txw[dptr];
              dptr   <= dptr - 4'd1;
            end
            if (last_edge) st <= S_TAIL;
            else           ecnt <= ecnt + 5'd1;
          end else cnt <= cnt - BRW'(1);
        S_TAIL:
          if (tick) begin
            st    <= S_IDLE;
            pcs_q <= '1;
          end else cnt <= cnt - BRW'(1);
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                 done_q <= 1'b0;
    else if (start_ok)                          done_q <= 1'b0;
    else if (fin && ptr == qend_q && !fault)    done_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        modf_q <= 1'b0;
    else if (fault)    modf_q <= 1'b1;
    else if (start_ok) modf_q <= 1'b0;

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!busy && pcs == '1 && modf));

  p_cs_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> pcs == '1);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && tick && samp_edge && !fault) |=> $stable(mosi));

  p_go_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go && !(mstr_en && ss_n)) |=> !busy);
endmodule

// File: tb/tb_qspi_master.sv
module tb_qspi_master;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic mstr_en = 1, cpol = 1, cpha = 0, go = 0, wr_en = 0, wr_tx = 0;
  logic miso = 0, ss_n = 1;
  logic [7:0]  baud = 8'd2;
  logic [3:0]  qstart = 0, qend = 0, wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic sck, mosi, busy, done, modf;
  logic [3:0] pcs;

  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  qspi_master dut (
    .clk(clk), .rst_n(rst_n), .mstr_en(mstr_en), .cpol(cpol), .cpha(cpha),
    .baud(baud), .qstart(qstart), .qend(qend), .go(go), .wr_en(wr_en),
    .wr_tx(wr_tx), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .sck(sck), .mosi(mosi), .pcs(pcs), .miso(miso),
    .ss_n(ss_n), .busy(busy), .done(done), .modf(modf));

  logic [7:0]  b_cmd [16];
  logic [15:0] b_tx  [16];
  logic [15:0] b_sl  [16];
  int seq [16];
  int seq_n;

  logic        mon_on = 0;
  int          m_pha, m_bd, pos, k, hp_bad, tot_edges, me, mn;
  logic [15:0] sl, mo;
  logic [15:0] got_mo [16];
  logic [3:0]  got_cs [16];
  time         t_last;
  int          sck_chg = 0;
  logic        chg_on = 0;

  function automatic int exp_len(input logic [3:0] c);
    if (c == 0) return 16;
    if (c < 8)  return 8;
    return int'(c);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(sck) if (chg_on) sck_chg++;

  always @(sck) if (mon_on && busy && pos < seq_n) begin
    me = seq[pos];
    mn = exp_len(b_cmd[me][7:4]);
    if (k > 0 && ($time - t_last) != m_bd * CLK_P) hp_bad++;
    t_last = $time;
    tot_edges++;
    if ((k % 2) == m_pha) begin
      mo = {mo[14:0], mosi};
      if (k < 2) got_cs[pos] = pcs;
    end else if (!(m_pha == 0 && k == 2*mn - 1)) begin
      miso = sl[15];
      sl = {sl[14:0], 1'b0};
    end
    k++;
    if (k == 2*mn) begin
      got_mo[pos] = mo;
      pos++; k = 0; mo = 0;
      if (pos < seq_n) begin
        sl = b_sl[seq[pos]];
        if (m_pha == 0) begin miso = sl[15]; sl = {sl[14:0], 1'b0}; end
      end
    end
  end

  task automatic wr(input bit tx, input int a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_tx = tx; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic prog(input int e, input logic [3:0] code, input logic [3:0] cs,
                      input logic [15:0] tx, input logic [15:0] slv);
    b_cmd[e] = {code, cs}; b_tx[e] = tx; b_sl[e] = slv;
    wr(0, e, {8'h00, code, cs});   // R11: command word, length in [7:4], select in [3:0]
    wr(1, e, tx);                  // R11: transmit word
  endtask

  task automatic pulse_go();
    @(negedge clk); go = 1;
    @(negedge clk); go = 0;
  endtask

  task automatic run_q(input int qs, input int qe, input int bd, input bit pol, input bit pha);
    int n, e, to;
    logic [15:0] m;
    seq_n = 0;
    for (int i = qs; ; i = (i + 1) % 16) begin
      seq[seq_n++] = i;
      if (i == qe) break;
    end
    @(negedge clk);
    cpol = pol; cpha = pha; baud = 8'(bd); qstart = 4'(qs); qend = 4'(qe);
    m_pha = pha; m_bd = (bd < 2) ? 2 : bd;
    pos = 0; k = 0; mo = 0; hp_bad = 0; tot_edges = 0;
    sl = b_sl[seq[0]];
    if (!pha) begin miso = sl[15]; sl = {sl[14:0], 1'b0}; end
    mon_on = 1;
    pulse_go();
    to = 0;
    while (!done && to < 20000) begin @(negedge clk); to++; end
    mon_on = 0;
    check(done && !busy, "R8 done after last entry", {done, busy}, 2'b10);
    check(sck == pol, "R2 sck idle level", sck, pol);
    check(hp_bad == 0, "R5 edge spacing", hp_bad, 0);
    n = 0;
    for (int p = 0; p < seq_n; p++) n += 2 * exp_len(b_cmd[seq[p]][7:4]);
    check(tot_edges == n, "R4 edge count", tot_edges, n);
    for (int p = 0; p < seq_n; p++) begin
      e = seq[p];
      n = exp_len(b_cmd[e][7:4]);
      m = (n == 16) ? 16'hFFFF : 16'((1 << n) - 1);
      check(got_mo[p] == (b_tx[e] & m), "R3 mosi word", got_mo[p], b_tx[e] & m);
      check(got_cs[p] == b_cmd[e][3:0], "R6 chip select", got_cs[p], b_cmd[e][3:0]);
      rd_addr = 4'(e);
      #1;
      check(rd_data == (b_sl[e] >> (16 - n)), "R7 receive word", rd_data, b_sl[e] >> (16 - n));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!busy && !done && !modf, "R1 flags", {busy, done, modf}, 0);
    check(pcs == 4'hF, "R1 pcs", pcs, 4'hF);
    check(sck == cpol, "R1 sck", sck, cpol);
  endtask

  task automatic t_modes();
    for (int md = 0; md < 4; md++) run_q(0, 3, 2 + md, md[1], md[0]);   // R2 all four modes
  endtask

  task automatic t_baud();
    run_q(1, 1, 0, 0, 1);   // R5 baud 0 behaves as 2
    run_q(2, 2, 7, 1, 0);   // R5 baud 7
  endtask

  task automatic t_wrap();
    prog(14, 4'd10, 4'h3, 16'h02AB, 16'hE1C0);
    prog(15, 4'd9,  4'h5, 16'h0155, 16'h9F80);
    run_q(14, 1, 3, 0, 0);  // R6 wrap 14,15,0,1
  endtask

  task automatic t_done();
    check(done, "R8 done held", done, 1);
    pulse_go();
    check(busy && !done, "R8 go clears done", {busy, done}, 2'b10);
    while (!done) @(negedge clk);
  endtask

  task automatic t_fault();
    qstart = 0; qend = 0; baud = 8'd4; cpol = 1; cpha = 1;
    pulse_go();
    repeat (30) @(negedge clk);
    check(busy, "R9 transfer running", busy, 1);
    ss_n = 0;
    @(negedge clk);
    check(modf && !busy, "R9 fault aborts", {modf, busy}, 2'b10);
    check(pcs == 4'hF && sck == cpol, "R9 pins idle", {pcs, sck}, {4'hF, cpol});
    check(!done, "R9 no done", done, 0);
    ss_n = 1;
    repeat (3) @(negedge clk);
    check(modf, "R9 modf sticky", modf, 1);
    pulse_go();
    check(!modf && busy, "R9 go clears modf", {modf, busy}, 2'b01);
    while (!done) @(negedge clk);
  endtask

  task automatic t_ignore();
    mstr_en = 0; sck_chg = 0; chg_on = 1;
    pulse_go();
    repeat (40) @(negedge clk);
    check(!busy && sck_chg == 0, "R10 go ignored without master", {busy, 8'(sck_chg)}, 0);
    check(done, "R10 done kept", done, 1);
    mstr_en = 1; ss_n = 0;
    pulse_go();
    repeat (40) @(negedge clk);
    check(!busy && sck_chg == 0, "R10 go ignored with ss_n low", {busy, 8'(sck_chg)}, 0);
    chg_on = 0; ss_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    prog(0, 4'd0,  4'hE, 16'hA5C3, 16'h3C5A);
    prog(1, 4'd8,  4'hD, 16'h00B7, 16'hC900);
    prog(2, 4'd3,  4'hB, 16'h1269, 16'h6D00);
    prog(3, 4'd12, 4'h7, 16'h0F1E, 16'h8A50);
    t_modes();
    t_baud();
    t_wrap();
    t_done();
    t_fault();
    t_ignore();
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end
endmodule